// File: doc/BRIEF.md
# Lane-partitioned SIMD integer ALU

This block does integer arithmetic on two 128-bit operands that are split into independent lanes. An arrangement code sets the element size: sixteen 8-bit lanes, eight 16-bit, four 32-bit or two 64-bit. Lane 0 always holds the least significant bits. No carry or product bit crosses from one lane into the next. Lane-wise add and lane-wise multiply work in every arrangement, and both wrap modulo the lane width.

Three more forms run on fixed sizes:
- A narrowing add sums four 32-bit lanes and packs each 16-bit result into the low half of the output.
- A widening add sums the four 16-bit lanes in the low halves of the operands and gives 32-bit results. Each input is zero-extended or sign-extended, as the sign input selects.
- A by-element multiply-accumulate broadcasts one chosen 32-bit lane of the second operand. It multiplies each first-operand lane by that value and adds the product to the matching accumulator lane.

The result is registered once. It appears on the first rising clock edge after the inputs are applied.

Top module: `simd_lane_alu`

## Requirements
- R1: For op 0 (add) and op 1 (multiply), the arrangement code arr selects the lane size: 0 gives 8-bit lanes, 1 gives 16-bit, 2 gives 32-bit and 3 gives 64-bit. Lane i occupies bits [i*w +: w]. No lane's result depends on another lane's inputs.
- R2: Op 0 puts (a_i + b_i) mod 2^w in each lane.
- R3: Op 1 puts the low w bits of a_i * b_i in each lane.
- R4: Op 2 (narrowing add) ignores arr. For each of the four 32-bit lanes i, it puts the low 16 bits of a_i + b_i at result bits [16i +: 16] and drives bits 127:64 to zero.
- R5: Op 3 (widening add) ignores arr and operand bits 127:64. It adds the four 16-bit lanes of bits 63:0 and puts each 32-bit sum at [32i +: 32]. Inputs are zero-extended when sgn_i is 0 and sign-extended when sgn_i is 1.
- R6: Op 4 (by-element multiply-accumulate) ignores arr. Result lane i of 32 bits is (acc_i + a_i * b[idx_i]) mod 2^32, where idx_i selects b lane 0 to 3.
- R7: Op codes 5, 6 and 7 give an all-zero result.
- R8: While rst_n is low, the result is cleared to zero at each rising edge.
- R9: The result is updated only on a rising edge, from the inputs present at that edge, and holds between edges.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| op_i | input | 3 | Operation code: 0 add, 1 multiply, 2 narrowing add, 3 widening add, 4 by-element multiply-accumulate |
| arr_i | input | 2 | Lane size for ops 0 and 1: 0 = 8, 1 = 16, 2 = 32, 3 = 64 bits |
| idx_i | input | 2 | Lane of b that op 4 broadcasts |
| sgn_i | input | 1 | Sign-extend inputs for the widening add |
| a_i | input | 128 | First operand |
| b_i | input | 128 | Second operand |
| acc_i | input | 128 | Accumulator for op 4 |
| res_o | output | 128 | Registered result |

## Verification
Two effects occur in the same cycle: each lane wraps on its own, and the carry is cut at every lane boundary. The bench provokes this with all-ones operands added to small values, in every arrangement. It checks that every lane lands on its own wrapped value and that no carry reaches the next lane; a full-width carry would leave a nonzero pattern. The multiply-accumulate is driven the same way. The product overflows 32 bits at the same moment as the accumulator add, and the check expects the accumulator term alone to survive in the result.

// File: rtl/simd_lane_alu.sv
module simd_lane_alu #(
  parameter int W = 128
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [2:0]   op_i,
  input  logic [1:0]   arr_i,
  input  logic [1:0]   idx_i,
  input  logic         sgn_i,
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  input  logic [W-1:0] acc_i,
  output logic [W-1:0] res_o
);
  localparam int NB = W / 8;
  localparam int NH = W / 16;
  localparam int NS = W / 32;
  localparam int ND = W / 64;

  logic [W-1:0] nxt;
  logic [31:0]  sc;
  logic [31:0]  wa, wb;

  assign sc = b_i[idx_i*32 +: 32];

  always_comb begin
    nxt = '0;
    wa  = '0;
    wb  = '0;
    case (op_i)
      3'd0, 3'd1: begin
        case (arr_i)
          2'd0: for (int i = 0; i < NB; i++)
                  nxt[i*8 +: 8] = (op_i == 3'd0) ? a_i[i*8 +: 8] + b_i[i*8 +: 8]
                                                 : a_i[i*8 +: 8] * b_i[i*8 +: 8];
          2'd1: for (int i = 0; i < NH; i++)
                  nxt[i*16 +: 16] = (op_i == 3'd0) ? a_i[i*16 +: 16] + b_i[i*16 +: 16]
                                                   : a_i[i*16 +: 16] * b_i[i*16 +: 16];
          2'd2: for (int i = 0; i < NS; i++)
                  nxt[i*32 +: 32] = (op_i == 3'd0) ? a_i[i*32 +: 32] + b_i[i*32 +: 32]
                                                   : a_i[i*32 +: 32] * b_i[i*32 +: 32];
          default: for (int i = 0; i < ND; i++)
                  nxt[i*64 +: 64] = (op_i == 3'd0) ? a_i[i*64 +: 64] + b_i[i*64 +: 64]
                                                   : a_i[i*64 +: 64] * b_i[i*64 +: 64];
        endcase
      end
      3'd2: for (int i = 0; i < NS; i++)
              nxt[i*16 +: 16] = a_i[i*32 +: 16] + b_i[i*32 +: 16];
      3'd3: for (int i = 0; i < NS; i++) begin
              wa = {{16{sgn_i & a_i[i*16+15]}}, a_i[i*16 +: 16]};
              wb = {{16{sgn_i & b_i[i*16+15]}}, b_i[i*16 +: 16]};
              nxt[i*32 +: 32] = wa + wb;
            end
      3'd4: for (int i = 0; i < NS; i++)
              nxt[i*32 +: 32] = acc_i[i*32 +: 32] + a_i[i*32 +: 32] * sc;
      default: nxt = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) res_o <= '0;
    else        res_o <= nxt;
  end

  a_r2_byte_lane0: assert property (@(posedge clk) disable iff (!rst_n)
    (op_i == 3'd0 && arr_i == 2'd0) |=> res_o[7:0] == $past(a_i[7:0] + b_i[7:0]));

  a_r1_no_cross_carry: assert property (@(posedge clk) disable iff (!rst_n)
    (op_i == 3'd0 && arr_i == 2'd1 && a_i[31:16] == 16'h0 && b_i[31:16] == 16'h0)
      |=> res_o[31:16] == 16'h0);

  a_r4_narrow_upper_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (op_i == 3'd2) |=> res_o[W-1:64] == '0);

  a_r5_wide_ignores_upper: assert property (@(posedge clk) disable iff (!rst_n)
    (op_i == 3'd3 && a_i[63:0] == 64'h0 && b_i[63:0] == 64'h0) |=> res_o == '0);

  a_r6_mla_zero_a: assert property (@(posedge clk) disable iff (!rst_n)
    (op_i == 3'd4 && a_i == '0) |=> res_o == $past(acc_i));

  a_r7_bad_op_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (op_i > 3'd4) |=> res_o == '0);
endmodule

// File: tb/sim_simd_lane_alu.sv
module sim_simd_lane_alu;
  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic [2:0]   op = '0;
  logic [1:0]   arr = '0;
  logic [1:0]   idx = '0;
  logic         sgn = 1'b0;
  logic [127:0] a = '0, b = '0, c = '0;
  logic [127:0] res;
  int checks = 0, errors = 0;
  bit done = 0;

  always #10 clk = ~clk;

  simd_lane_alu u0 (.clk(clk), .rst_n(rst_n), .op_i(op), .arr_i(arr), .idx_i(idx),
                    .sgn_i(sgn), .a_i(a), .b_i(b), .acc_i(c), .res_o(res));

  typedef struct packed {
    logic [2:0]   op;
    logic [1:0]   arr;
    logic [1:0]   idx;
    logic         sg;
    logic [127:0] a;
    logic [127:0] b;
    logic [127:0] c;
    logic [127:0] e;
    logic [7:0]   tag;
  } vec_t;

  localparam int NV = 17;
  localparam vec_t V [NV] = '{
    // R2 halfword add with wrap
    '{3'd0, 2'd1, 2'd0, 1'b0, 128'h0001_FFFF_0002_8000_7FFF_0000_1234_FFFF,
      128'h0001_0001_0003_8000_0001_0000_1111_0002, 128'h0,
      128'h0002_0000_0005_0000_8000_0000_2345_0001, 8'd2},
    // R1 byte lanes: carry must not cross
    '{3'd0, 2'd0, 2'd0, 1'b0, {16{8'hFF}}, {16{8'h01}}, 128'h0, 128'h0, 8'd1},
    // R1 word lanes
    '{3'd0, 2'd2, 2'd0, 1'b0, {4{32'hFFFFFFFF}}, {4{32'h1}}, 128'h0, 128'h0, 8'd1},
    // R1 doubleword lanes
    '{3'd0, 2'd3, 2'd0, 1'b0, 128'h0000000000000001_FFFFFFFFFFFFFFFF, 128'h1, 128'h0,
      128'h0000000000000001_0000000000000000, 8'd1},
    // R3 multiply byte lanes
    '{3'd1, 2'd0, 2'd0, 1'b0, {16{8'h10}}, {16{8'h11}}, 128'h0, {16{8'h10}}, 8'd3},
    '{3'd1, 2'd0, 2'd0, 1'b0, {16{8'h03}}, {16{8'h05}}, 128'h0, {16{8'h0F}}, 8'd3},
    '{3'd1, 2'd1, 2'd0, 1'b0, {8{16'h0100}}, {8{16'h0101}}, 128'h0, {8{16'h0100}}, 8'd3},
    '{3'd1, 2'd2, 2'd0, 1'b0, {4{32'h00010000}}, {4{32'h00010003}}, 128'h0,
      {4{32'h00030000}}, 8'd3},
    '{3'd1, 2'd3, 2'd0, 1'b0, {2{64'h2}}, {2{64'h8000000000000001}}, 128'h0,
      {2{64'h2}}, 8'd3},
    // R4 narrowing add
    '{3'd2, 2'd0, 2'd0, 1'b0, {4{32'h0001FFFF}}, {4{32'h00000003}}, 128'h0,
      {64'h0, {4{16'h0002}}}, 8'd4},
    // R5 widening add, unsigned, with upper operand bits set
    '{3'd3, 2'd1, 2'd0, 1'b0, {128{1'b1}}, {64'hFFFFFFFFFFFFFFFF, {4{16'h0001}}}, 128'h0,
      {4{32'h00010000}}, 8'd5},
    // R5 signed
    '{3'd3, 2'd1, 2'd0, 1'b1, {128{1'b1}}, {64'hFFFFFFFFFFFFFFFF, {4{16'h0001}}}, 128'h0,
      128'h0, 8'd5},
    '{3'd3, 2'd0, 2'd0, 1'b1, {64'h0, {4{16'h8000}}}, {64'h0, {4{16'h8000}}}, 128'h0,
      {4{32'hFFFF0000}}, 8'd5},
    // R6 by-element multiply-accumulate
    '{3'd4, 2'd0, 2'd2, 1'b0, {32'd4, 32'd3, 32'd2, 32'd1}, {32'd0, 32'd10, 32'd0, 32'd0},
      {4{32'd5}}, {32'd45, 32'd35, 32'd25, 32'd15}, 8'd6},
    '{3'd4, 2'd3, 2'd0, 1'b0, {32'd4, 32'd3, 32'd2, 32'd1}, {32'd100, 32'd200, 32'd300, 32'd7},
      128'h0, {32'd28, 32'd21, 32'd14, 32'd7}, 8'd6},
    '{3'd4, 2'd1, 2'd3, 1'b0, {4{32'h80000000}}, {32'd2, 96'h0}, {4{32'd1}},
      {4{32'd1}}, 8'd6},
    // R7 unused op
    '{3'd5, 2'd0, 2'd0, 1'b0, {128{1'b1}}, {128{1'b1}}, {128{1'b1}}, 128'h0, 8'd7}
  };

  task automatic check(input string req, input logic [127:0] exp);
    checks++;
    if (res !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", req, res, exp);
    end
  endtask

  initial begin
    #1000000;
    if (!done) begin
      errors++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    a = {128{1'b1}}; b = {128{1'b1}}; op = 3'd0;
    repeat (2) @(negedge clk);
    check("R8 reset", 128'h0);
    rst_n = 1'b1;
    for (int k = 0; k < NV; k++) begin
      @(negedge clk);
      op = V[k].op; arr = V[k].arr; idx = V[k].idx; sgn = V[k].sg;
      a = V[k].a; b = V[k].b; c = V[k].c;
      @(negedge clk);
      check($sformatf("R%0d vector %0d", V[k].tag, k), V[k].e);
    end
    // R9 registered timing
    op = 3'd0; arr = 2'd0; a = 128'h1; b = 128'h1;
    @(negedge clk);
    check("R9 first value", 128'h2);
    a = 128'h5; b = 128'h5;
    #5;
    check("R9 hold before edge", 128'h2);
    @(negedge clk);
    check("R9 update after edge", 128'hA);
    // R8 reset mid-run
    rst_n = 1'b0;
    @(negedge clk);
    check("R8 mid-run reset", 128'h0);
    rst_n = 1'b1;
    done = 1;
    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule